// File: doc/BRIEF.md
# Boot Download and Reset Sequencer

This block governs start-up for a rule-processing coprocessor. It holds an internal core reset for a fixed number of clocks after the active-low preset is sampled low, and again after every change of the offline mode input. While the offline input is high and the hold has expired, it loads a boot image into an internal configuration RAM. The host can pick either of two ways to feed the image:

- **Automatic mode.** The block divides the master clock into a slow read strobe toward an external boot memory. It captures one byte per strobe period.
- **Manual mode.** The host offers each byte with a read request. The block answers with a four-phase ready handshake.

The image is a stream of three-byte records: address high, address low, then data. Each complete record produces one write pulse toward the RAM. A record whose address is all ones ends the download. It raises the end-of-download flag, and the host may then lower the offline input to start the online phase.

Top module: `boot_loader_seq`

## Requirements
- R1: When `preset_n` is sampled low at a rising edge, `core_rst` reads high during the 3 clock cycles that follow the last such edge, and reads low afterwards. While `core_rst` is high, `host_ready`, `cfg_we` and `dl_done` are low. This step also clears any partly received record.
- R2: Any change of `offline` seen at a rising edge raises `core_rst` for the next 3 cycles. It clears `dl_done` and discards any partly received record.
- R3: No loading happens while `offline` is low or `core_rst` is high. In that state `mem_rd` stays low and `host_ready` never rises.
- R4: In automatic mode (`offline`=1, `auto_boot`=1, not done, no hold), `mem_rd` is a periodic strobe with a 50% duty cycle. Its period in clocks is set by `speed_sel`: code 0 gives 32, 1 gives 16, 2 gives 8, 3 gives 4, and codes 4 to 7 give 32. The strobe starts high in the first cycle after the hold ends.
- R5: In automatic mode, `boot_din` is captured at the rising edge that ends the last high cycle of each `mem_rd` pulse.
- R6: In manual mode (`offline`=1, `auto_boot`=0), a byte is taken at an edge where `host_rd` is high and `host_ready` is low. `host_ready` is high from the next cycle and stays high while `host_rd` stays high. It drops in the cycle after `host_rd` is seen low.
- R7: Bytes form records in the order address high, address low, data. After the data byte is taken, `cfg_we` is high for exactly one cycle, with `cfg_addr` holding {high, low} and `cfg_data` holding the data byte.
- R8: When the two address bytes of a record are 0xFF and 0xFF, no write occurs and `dl_done` goes high in the next cycle. It then stays high until the next hold. After that point no strobe is generated and no further byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| preset_n | input | 1 | Active-low synchronous preset |
| offline | input | 1 | High selects the download phase |
| auto_boot | input | 1 | High selects automatic loading from boot memory |
| speed_sel | input | 3 | Strobe divider code for automatic mode |
| boot_din | input | 8 | Byte input bus |
| host_rd | input | 1 | Host read request in manual mode |
| host_ready | output | 1 | Byte stored acknowledgement in manual mode |
| mem_rd | output | 1 | Divided read strobe toward boot memory |
| core_rst | output | 1 | Internal reset hold |
| cfg_we | output | 1 | One-cycle write pulse to configuration RAM |
| cfg_addr | output | 16 | Write address |
| cfg_data | output | 8 | Write data |
| dl_done | output | 1 | End of download |

## Verification
The bench releases preset and checks that the hold lasts exactly three cycles; an off-by-one counter would shorten or stretch it. It breaks records in half with a mode toggle and with a preset, then sends a fresh record. A framer that is not cleared would write to a mixed-up address. The strobe period and high time are measured for several divider codes, including an unused one, so a wrong ratio or fallback shows up. The bench also checks that reads are refused once the terminator is seen and while online, where a design with loose gating would raise ready or keep strobing.

// File: rtl/boot_seq_pkg.sv
// Package: shared types and the divider-ratio decode for the boot sequencer.
// Assumes the strobe ratio never exceeds MAX_RATIO.
package boot_seq_pkg;

    localparam int MAX_RATIO = 32;

    typedef enum logic [1:0] {
        PH_ADDR_HI = 2'd0,
        PH_ADDR_LO = 2'd1,
        PH_DATA    = 2'd2
    } frame_ph_e;

    // Maps a speed code to its strobe period in master-clock cycles.
    function automatic int unsigned strobe_ratio(input logic [2:0] code);
        case (code)
            3'd1:    return 16;
            3'd2:    return 8;
            3'd3:    return 4;
            default: return MAX_RATIO;
        endcase
    endfunction

endpackage

// File: rtl/boot_rst_hold.sv
// Reset hold: counts HOLD_CYC cycles after preset low or any mode change.
// Assumes mode_in is already synchronous to clk.
module boot_rst_hold #(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic preset_n,
    input  logic mode_in,
    output logic hold_o,
    output logic clear_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] cnt;
    logic          mode_q;
    logic          mode_edge;

    assign mode_edge = (mode_in != mode_q);
    assign hold_o    = (cnt != '0);
    assign clear_o   = !preset_n || mode_edge || hold_o;

    // Reload the counter on preset or mode edge, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!preset_n) begin
            cnt    <= CW'(HOLD_CYC);
            mode_q <= mode_in;
        end else if (mode_edge) begin
            cnt    <= CW'(HOLD_CYC);
            mode_q <= mode_in;
        end else if (hold_o) begin
            cnt    <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/boot_strobe_div.sv
// Strobe divider: makes a 50% duty read strobe and a one-cycle capture pulse
// at the end of its high half. Assumes every ratio is even and at most 2**CNT_W.
module boot_strobe_div
    import boot_seq_pkg::*;
#(
    parameter int CNT_W = $clog2(MAX_RATIO)
) (
    input  logic       clk,
    input  logic       clear,
    input  logic       enable,
    input  logic [2:0] speed_sel,
    output logic       strobe_o,
    output logic       take_o
);
    localparam int RW = CNT_W + 1;

    logic [RW-1:0]    ratio;
    logic [RW-1:0]    half;
    logic [CNT_W-1:0] cnt;
    logic [RW-1:0]    cnt_x;

    assign ratio = RW'(strobe_ratio(speed_sel));
    assign half  = ratio >> 1;
    assign cnt_x = {1'b0, cnt};

    // Phase counter wraps at the selected ratio and idles at zero when disabled.
    always_ff @(posedge clk) begin
        if (clear || !enable) begin
            cnt <= '0;
        end else if (cnt_x >= ratio - 1'b1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign strobe_o = enable && (cnt_x < half);
    assign take_o   = enable && (cnt_x == half - 1'b1);

endmodule

// File: rtl/boot_byte_framer.sv
// Byte framer: assembles high/low/data records, issues a write pulse per record
// and flags completion on the all-ones address. Assumes take is a single pulse.
module boot_byte_framer
    import boot_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  clear,
    input  logic                  take,
    input  logic [DATA_W-1:0]     din,
    output logic                  cfg_we,
    output logic [2*DATA_W-1:0]   cfg_addr,
    output logic [DATA_W-1:0]     cfg_data,
    output logic                  done
);
    localparam int AW = 2 * DATA_W;
    localparam logic [AW-1:0] END_ADDR = '1;

    frame_ph_e       ph;
    logic [DATA_W-1:0] hi_q;
    logic [AW-1:0]     addr_nxt;

    assign addr_nxt = {hi_q, din};

    // Step through the record fields and emit writes or the done flag.
    always_ff @(posedge clk) begin
        if (clear) begin
            ph       <= PH_ADDR_HI;
            hi_q     <= '0;
            cfg_we   <= 1'b0;
            cfg_addr <= '0;
            cfg_data <= '0;
            done     <= 1'b0;
        end else begin
            cfg_we <= 1'b0;
            if (take && !done) begin
                case (ph)
                    PH_ADDR_HI: begin
                        hi_q <= din;
                        ph   <= PH_ADDR_LO;
                    end
                    PH_ADDR_LO: begin
                        cfg_addr <= addr_nxt;
                        if (addr_nxt == END_ADDR) begin
                            done <= 1'b1;
                            ph   <= PH_ADDR_HI;
                        end else begin
                            ph   <= PH_DATA;
                        end
                    end
                    PH_DATA: begin
                        cfg_we   <= 1'b1;
                        cfg_data <= din;
                        ph       <= PH_ADDR_HI;
                    end
                    default: ph <= PH_ADDR_HI;
                endcase
            end
        end
    end

endmodule

// File: rtl/boot_loader_seq.sv
// Top: boot download and reset sequencer. Combines the reset hold, the
// automatic strobe divider, the manual ready handshake and the record framer.
// Assumes all inputs are synchronous to clk.
module boot_loader_seq
    import boot_seq_pkg::*;
#(
    parameter int  DATA_W   = 8,
    parameter int  HOLD_CYC = 3,
    localparam int ADDR_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              preset_n,
    input  logic              offline,
    input  logic              auto_boot,
    input  logic [2:0]        speed_sel,
    input  logic [DATA_W-1:0] boot_din,
    input  logic              host_rd,
    output logic              host_ready,
    output logic              mem_rd,
    output logic              core_rst,
    output logic              cfg_we,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [DATA_W-1:0] cfg_data,
    output logic              dl_done
);
    logic hold;
    logic clear;
    logic auto_en;
    logic auto_take;
    logic man_take;
    logic take;
    logic ready_q;

    boot_rst_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk      (clk),
        .preset_n (preset_n),
        .mode_in  (offline),
        .hold_o   (hold),
        .clear_o  (clear)
    );

    assign auto_en  = offline && auto_boot && !dl_done && !hold;
    assign man_take = offline && !auto_boot && !dl_done && !hold
                      && host_rd && !ready_q;

    boot_strobe_div u_div (
        .clk       (clk),
        .clear     (clear),
        .enable    (auto_en),
        .speed_sel (speed_sel),
        .strobe_o  (mem_rd),
        .take_o    (auto_take)
    );

    // Four-phase ready: set on a stored byte, cleared once read is withdrawn.
    always_ff @(posedge clk) begin
        if (clear) begin
            ready_q <= 1'b0;
        end else if (!host_rd) begin
            ready_q <= 1'b0;
        end else if (man_take) begin
            ready_q <= 1'b1;
        end
    end

    assign take = auto_take || man_take;

    boot_byte_framer #(.DATA_W(DATA_W)) u_frame (
        .clk      (clk),
        .clear    (clear),
        .take     (take),
        .din      (boot_din),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .done     (dl_done)
    );

    assign host_ready = ready_q;
    assign core_rst   = hold;

endmodule

// File: rtl/boot_loader_seq_chk.sv
// Checker: temporal properties of the boot sequencer ports, bound to the top.
module boot_loader_seq_chk (
    input logic clk,
    input logic preset_n,
    input logic offline,
    input logic host_rd,
    input logic host_ready,
    input logic mem_rd,
    input logic core_rst,
    input logic cfg_we,
    input logic dl_done
);
    // R1: release from preset finds the hold active
    assert_hold_on_release_R1: assert property (@(posedge clk) disable iff (!preset_n)
        $rose(preset_n) |-> core_rst);

    // R1: outputs quiet during the hold
    assert_quiet_in_hold_R1: assert property (@(posedge clk) disable iff (!preset_n)
        core_rst |-> (!host_ready && !cfg_we && !dl_done));

    // R2: a mode change starts a hold
    assert_hold_on_mode_R2: assert property (@(posedge clk) disable iff (!preset_n)
        (offline != $past(offline)) |=> core_rst);

    // R3: no strobe online or in hold
    assert_no_strobe_idle_R3: assert property (@(posedge clk) disable iff (!preset_n)
        (!offline || core_rst) |-> !mem_rd);

    // R6: ready drops after read is withdrawn
    assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!preset_n)
        (host_ready && !host_rd) |=> !host_ready);

    // R6: ready only rises in answer to a read
    assert_ready_cause_R6: assert property (@(posedge clk) disable iff (!preset_n)
        $rose(host_ready) |-> $past(host_rd));

    // R7: write strobe lasts one cycle
    assert_we_pulse_R7: assert property (@(posedge clk) disable iff (!preset_n)
        cfg_we |=> !cfg_we);

    // R8: done persists until a hold
    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!preset_n)
        dl_done |=> (dl_done || core_rst));

    // R8: no strobe after done
    assert_done_no_strobe_R8: assert property (@(posedge clk) disable iff (!preset_n)
        dl_done |-> !mem_rd);

endmodule

bind boot_loader_seq boot_loader_seq_chk u_chk (
    .clk        (clk),
    .preset_n   (preset_n),
    .offline    (offline),
    .host_rd    (host_rd),
    .host_ready (host_ready),
    .mem_rd     (mem_rd),
    .core_rst   (core_rst),
    .cfg_we     (cfg_we),
    .dl_done    (dl_done)
);

// File: tb/boot_loader_seq_test.sv
module boot_loader_seq_test;

    logic        clk = 1'b0;
    logic        preset_n, offline, auto_boot, host_rd;
    logic [2:0]  speed_sel;
    logic [7:0]  boot_din;
    logic        host_ready, mem_rd, core_rst, cfg_we, dl_done;
    logic [15:0] cfg_addr;
    logic [7:0]  cfg_data;

    always #10 clk = ~clk;

    boot_loader_seq uut (
        .clk(clk), .preset_n(preset_n), .offline(offline), .auto_boot(auto_boot),
        .speed_sel(speed_sel), .boot_din(boot_din), .host_rd(host_rd),
        .host_ready(host_ready), .mem_rd(mem_rd), .core_rst(core_rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .dl_done(dl_done)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // ---------------- behavioural reference ----------------
    int          m_hold = 0;
    logic        m_offq = 1'b0;
    int          m_ph = 0;
    logic [7:0]  m_hi = 8'h00;
    logic [15:0] m_addr = 16'h0000;
    logic [7:0]  m_dat = 8'h00;
    logic        m_we = 1'b0, m_done = 1'b0, m_rdy = 1'b0, m_valid = 1'b0;
    int          m_div = 0;

    function automatic int ratio_of(input logic [2:0] c);
        case (c)
            3'd1: return 16;
            3'd2: return 8;
            3'd3: return 4;
            default: return 32;
        endcase
    endfunction

    task automatic m_clear();
        m_ph = 0; m_hi = 8'h00; m_addr = 16'h0000; m_dat = 8'h00;
        m_we = 1'b0; m_done = 1'b0; m_rdy = 1'b0; m_div = 0;
    endtask

    always @(posedge clk) begin : ref_model
        logic tk;
        int   n;
        tk = 1'b0;
        n  = ratio_of(speed_sel);
        if (!preset_n) begin
            m_hold = 3; m_offq = offline; m_clear(); m_valid = 1'b1;
        end else if (offline != m_offq) begin
            m_hold = 3; m_offq = offline; m_clear();
        end else if (m_hold > 0) begin
            m_hold = m_hold - 1; m_clear();
        end else begin
            m_we = 1'b0;
            if (offline && auto_boot && !m_done) begin
                if (m_div == n / 2 - 1) tk = 1'b1;
                m_div = (m_div >= n - 1) ? 0 : m_div + 1;
            end else begin
                m_div = 0;
            end
            if (!host_rd) m_rdy = 1'b0;
            else if (offline && !auto_boot && !m_done && !m_rdy) begin
                tk = 1'b1; m_rdy = 1'b1;
            end
            if (tk) begin
                case (m_ph)
                    0: begin m_hi = boot_din; m_ph = 1; end
                    1: begin
                        m_addr = {m_hi, boot_din};
                        if (m_addr == 16'hFFFF) begin m_done = 1'b1; m_ph = 0; end
                        else m_ph = 2;
                    end
                    default: begin m_we = 1'b1; m_dat = boot_din; m_ph = 0; end
                endcase
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [7:0]  img[$];
    int          img_idx = 0;
    logic        feed = 1'b0;
    logic        prev_rd = 1'b0;
    int          hi_run = 0, last_hi = 0, per_run = 0, last_per = 0;
    int          n_writes = 0;
    logic [15:0] last_wa = 16'h0;
    logic [7:0]  last_wd = 8'h0;

    // One clock: compare against the reference at the falling edge, then feed.
    task automatic tick();
        logic exp_rd;
        @(negedge clk);
        if (m_valid) begin
            exp_rd = (m_hold == 0) && offline && auto_boot && !m_done
                     && (m_div < ratio_of(speed_sel) / 2);
            chk("R1", "core_rst", {31'b0, core_rst}, {31'b0, m_hold != 0});
            chk("R4", "mem_rd", {31'b0, mem_rd}, {31'b0, exp_rd});
            chk("R6", "host_ready", {31'b0, host_ready}, {31'b0, m_rdy});
            chk("R7", "cfg_we", {31'b0, cfg_we}, {31'b0, m_we});
            chk("R8", "dl_done", {31'b0, dl_done}, {31'b0, m_done});
            if (m_we) begin
                chk("R7", "cfg_addr", {16'b0, cfg_addr}, {16'b0, m_addr});
                chk("R7", "cfg_data", {24'b0, cfg_data}, {24'b0, m_dat});
            end
        end
        if (cfg_we) begin n_writes++; last_wa = cfg_addr; last_wd = cfg_data; end
        if (mem_rd && !prev_rd) begin
            last_per = per_run; per_run = 0; hi_run = 0;
            if (feed && img_idx < img.size()) begin boot_din = img[img_idx]; img_idx++; end
        end
        per_run++;
        if (mem_rd) hi_run++;
        if (!mem_rd && prev_rd) last_hi = hi_run;
        prev_rd = mem_rd;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Manual four-phase byte transfer.
    task automatic host_byte(input logic [7:0] b);
        boot_din = b; host_rd = 1'b1;
        do tick(); while (!host_ready);
        host_rd = 1'b0;
        do tick(); while (host_ready);
    endtask

    // Automatic download of one record plus terminator at a given speed code.
    task automatic auto_run(input logic [2:0] code, input int n, input logic [15:0] a,
                            input logic [7:0] d);
        offline = 1'b0; auto_boot = 1'b1; speed_sel = code;
        ticks(5);
        img = {a[15:8], a[7:0], d, 8'hFF, 8'hFF};
        img_idx = 0; last_per = 0; last_hi = 0; feed = 1'b1;
        offline = 1'b1;
        do tick(); while (!dl_done);
        feed = 1'b0;
        chk("R4", "strobe high time", last_hi, n / 2);
        chk("R4", "strobe period", last_per, n);
        chk("R5", "auto write addr", {16'b0, last_wa}, {16'b0, a});
        chk("R5", "auto write data", {24'b0, last_wd}, {24'b0, d});
        ticks(2 * n);
        chk("R8", "no strobe after done", {31'b0, mem_rd}, 32'd0);
        chk("R8", "done stays", {31'b0, dl_done}, 32'd1);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        int w0;
        preset_n = 1'b0; offline = 1'b1; auto_boot = 1'b0; speed_sel = 3'd0;
        boot_din = 8'h00; host_rd = 1'b0;
        ticks(2);
        // R1: reset state and hold length after release
        chk("R1", "core_rst at release", {31'b0, core_rst}, 32'd1);
        chk("R1", "done in reset", {31'b0, dl_done}, 32'd0);
        preset_n = 1'b1;
        tick(); chk("R1", "hold cycle 2", {31'b0, core_rst}, 32'd1);
        tick(); chk("R1", "hold cycle 3", {31'b0, core_rst}, 32'd1);
        tick(); chk("R1", "hold over", {31'b0, core_rst}, 32'd0);

        // R6 R7 R8: manual download
        host_byte(8'h00); host_byte(8'h10); host_byte(8'hA5);
        chk("R7", "first write data", {24'b0, last_wd}, 32'hA5);
        host_byte(8'h12); host_byte(8'h34); host_byte(8'h5A);
        host_byte(8'hFF); host_byte(8'hFF);
        tick();
        chk("R8", "done after terminator", {31'b0, dl_done}, 32'd1);
        chk("R7", "write count", n_writes, 2);
        chk("R7", "last write addr", {16'b0, last_wa}, 32'h1234);
        w0 = n_writes;
        host_rd = 1'b1; boot_din = 8'h77; ticks(4);
        chk("R8", "read refused after done", {31'b0, host_ready}, 32'd0);
        host_rd = 1'b0; tick();
        chk("R8", "no write after done", n_writes, w0);

        // R2 R3: go online
        offline = 1'b0; tick();
        chk("R2", "hold on mode edge", {31'b0, core_rst}, 32'd1);
        chk("R2", "done cleared", {31'b0, dl_done}, 32'd0);
        ticks(4);
        host_rd = 1'b1; ticks(5);
        chk("R3", "no ready online", {31'b0, host_ready}, 32'd0);
        host_rd = 1'b0; auto_boot = 1'b1; ticks(6);
        chk("R3", "no strobe online", {31'b0, mem_rd}, 32'd0);
        auto_boot = 1'b0;

        // R2: partial record discarded by mode toggle
        offline = 1'b1; ticks(5);
        host_byte(8'h77);
        offline = 1'b0; ticks(4); offline = 1'b1; ticks(4);
        host_byte(8'h00); host_byte(8'h20); host_byte(8'hC3);
        chk("R2", "addr after toggle", {16'b0, last_wa}, 32'h0020);

        // R1: partial record discarded by preset
        host_byte(8'h55);
        preset_n = 1'b0; tick(); preset_n = 1'b1; ticks(4);
        host_byte(8'h00); host_byte(8'h30); host_byte(8'h3C);
        chk("R1", "addr after preset", {16'b0, last_wa}, 32'h0030);
        chk("R1", "data after preset", {24'b0, last_wd}, 32'h3C);

        // R4 R5 R8: automatic runs at several speeds, including an unused code
        auto_run(3'd1, 16, 16'h0102, 8'h11);
        auto_run(3'd0, 32, 16'h0203, 8'h22);
        auto_run(3'd3, 4,  16'h0304, 8'h33);
        auto_run(3'd6, 32, 16'h0405, 8'h44);
        auto_run(3'd2, 8,  16'h0506, 8'h55);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule